// File: doc/BRIEF.md
# Decode-Stage Hazard and Stall Controller

This block decides, in each cycle, whether the front of a five-stage in-order pipeline may advance. The five stages are fetch, decode, execute, memory and write-back. The block compares the source registers of the instruction in decode with the destination registers of the instructions in execute and memory. It also uses their register-write and load flags. From these it derives four outputs: a program-counter write enable, a fetch/decode register write enable, a bubble request, and a fetch/decode flush.

Conditional branches resolve in the decode stage. The block therefore also takes the two forwarded branch operands and the branch kind, evaluates the branch, and flushes the single instruction that was fetched behind a taken branch. A branch that still waits for an operand does not resolve in that cycle. The block is purely combinational. Its clock and reset serve only the embedded property checks.

Top module: `hazard_ctrl`

## Requirements
- R1: When the instruction in execute is a load (load flag 1, write flag 1, destination not 0) and its destination equals a source that the decode instruction uses, the pipeline stalls in that cycle. A non-branch consumer no longer stalls once the load has moved to memory, so the stall lasts one cycle.
- R2: Every stall cycle drives the bubble output to 1, so that the control bits entering the decode/execute register are cleared. Outside a stall the bubble output is 0.
- R3: The program-counter write enable and the fetch/decode write enable are both 0 in a stall cycle and both 1 otherwise.
- R4: A branch of kind 0 (equal) is taken when its two operands are equal. A branch of kind 1 (not-equal) is taken when they differ. A taken branch that is not stalled raises the flush output in that cycle.
- R5: A branch in decode that reads the destination of a non-load writer in execute stalls for one cycle. The same writer in memory causes no stall.
- R6: A branch in decode that reads the destination of a load stalls while the load is in execute and again while it is in memory, which makes two cycles in total.
- R7: Register 0 never causes a stall, whatever the stage flags are.
- R8: A producer whose write flag is 0 never causes a stall. A source whose use flag is 0 is never compared.
- R9: A branch that is stalled does not raise the flush output, even when its operands would make it taken.
- R10: An instruction that is not a branch never raises the flush output. When no hazard exists, both write enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| id_rs_i | input | REG_AW | First source register of the decode instruction |
| id_rt_i | input | REG_AW | Second source register of the decode instruction |
| id_use_rs_i | input | 1 | Decode instruction reads the first source |
| id_use_rt_i | input | 1 | Decode instruction reads the second source |
| id_branch_i | input | 1 | Decode instruction is a conditional branch |
| id_br_kind_i | input | 1 | Branch kind: 0 equal, 1 not-equal |
| id_opa_i | input | DATA_W | First forwarded branch operand |
| id_opb_i | input | DATA_W | Second forwarded branch operand |
| ex_rd_i | input | REG_AW | Destination register of the execute instruction |
| ex_wr_i | input | 1 | Execute instruction writes a register |
| ex_load_i | input | 1 | Execute instruction is a load |
| mem_rd_i | input | REG_AW | Destination register of the memory-stage instruction |
| mem_wr_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| pc_we_o | output | 1 | Program-counter write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| idex_bubble_o | output | 1 | Clear the control bits entering decode/execute |
| ifid_flush_o | output | 1 | Write a no-op into fetch/decode |

## Verification
A stall and a taken-branch flush can both be called for in one cycle. This happens when a branch with matching operands reads a register that an instruction in execute, or a load in memory, has yet to produce. The bench builds exactly that case and applies it. It expects the stall to win, with the flush held low. In the following cycle the producer has moved on, and the bench expects the flush to rise while the write enables return to 1.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
   typedef enum logic {
      BR_EQ = 1'b0,
      BR_NE = 1'b1
   } br_kind_e;

   localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hazard_src_match.sv
module hazard_src_match #(
   parameter int unsigned REG_AW    = 5,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic [REG_AW-1:0] src_i,
   input  logic              src_used_i,
   input  logic [REG_AW-1:0] dst_i,
   input  logic              dst_wr_i,
   output logic              hit_o
);
   logic same;
   assign same = src_used_i && dst_wr_i && (src_i == dst_i);

   generate
      if (ZERO_HARD) begin : g_zero_hard
         assign hit_o = same && (dst_i != '0);
      end else begin : g_zero_plain
         assign hit_o = same;
      end
   endgenerate
endmodule

// File: rtl/hazard_stage_probe.sv
module hazard_stage_probe #(
   parameter int unsigned REG_AW    = 5,
   parameter int unsigned NSRC      = 2,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic [NSRC-1:0][REG_AW-1:0] src_i,
   input  logic [NSRC-1:0]             src_used_i,
   input  logic [REG_AW-1:0]           dst_i,
   input  logic                        dst_wr_i,
   output logic                        hit_o
);
   logic [NSRC-1:0] hits;

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_src
         hazard_src_match #(
            .REG_AW   (REG_AW),
            .ZERO_HARD(ZERO_HARD)
         ) i_match (
            .src_i     (src_i[s]),
            .src_used_i(src_used_i[s]),
            .dst_i     (dst_i),
            .dst_wr_i  (dst_wr_i),
            .hit_o     (hits[s])
         );
      end
   endgenerate

   assign hit_o = |hits;
endmodule

// File: rtl/hazard_branch_resolve.sv
module hazard_branch_resolve
   import hazard_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              branch_i,
   input  logic              kind_i,
   input  logic [DATA_W-1:0] opa_i,
   input  logic [DATA_W-1:0] opb_i,
   output logic              taken_o
);
   br_kind_e kind;
   logic     equal;

   always_comb begin
      kind  = br_kind_e'(kind_i);
      equal = (opa_i == opb_i);
      unique case (kind)
         BR_EQ:   taken_o = branch_i && equal;
         BR_NE:   taken_o = branch_i && !equal;
         default: taken_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
   import hazard_pkg::*;
#(
   parameter int unsigned REG_AW    = 5,
   parameter int unsigned DATA_W    = 32,
   parameter bit          ZERO_HARD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] id_rs_i,
   input  logic [REG_AW-1:0] id_rt_i,
   input  logic              id_use_rs_i,
   input  logic              id_use_rt_i,
   input  logic              id_branch_i,
   input  logic              id_br_kind_i,
   input  logic [DATA_W-1:0] id_opa_i,
   input  logic [DATA_W-1:0] id_opb_i,
   input  logic [REG_AW-1:0] ex_rd_i,
   input  logic              ex_wr_i,
   input  logic              ex_load_i,
   input  logic [REG_AW-1:0] mem_rd_i,
   input  logic              mem_wr_i,
   input  logic              mem_load_i,
   output logic              pc_we_o,
   output logic              ifid_we_o,
   output logic              idex_bubble_o,
   output logic              ifid_flush_o
);
   localparam int unsigned NSRC = NUM_SRC;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("hazard_ctrl: REG_AW out of range");
      end
      if (DATA_W < 1) begin : g_bad_dw
         $error("hazard_ctrl: DATA_W must be positive");
      end
   endgenerate

   logic [NSRC-1:0][REG_AW-1:0] srcs;
   logic [NSRC-1:0]             used;
   logic                        ex_hit, mem_hit, taken;
   logic                        load_use, br_ex, br_mem_load, stall;

   assign srcs = {id_rt_i, id_rs_i};
   assign used = {id_use_rt_i, id_use_rs_i};

   hazard_stage_probe #(.REG_AW(REG_AW), .NSRC(NSRC), .ZERO_HARD(ZERO_HARD)) i_probe_ex (
      .src_i(srcs), .src_used_i(used), .dst_i(ex_rd_i), .dst_wr_i(ex_wr_i), .hit_o(ex_hit)
   );

   hazard_stage_probe #(.REG_AW(REG_AW), .NSRC(NSRC), .ZERO_HARD(ZERO_HARD)) i_probe_mem (
      .src_i(srcs), .src_used_i(used), .dst_i(mem_rd_i), .dst_wr_i(mem_wr_i), .hit_o(mem_hit)
   );

   hazard_branch_resolve #(.DATA_W(DATA_W)) i_resolve (
      .branch_i(id_branch_i), .kind_i(id_br_kind_i),
      .opa_i(id_opa_i), .opb_i(id_opb_i), .taken_o(taken)
   );

   always_comb begin
      load_use    = ex_hit && ex_load_i;
      br_ex       = ex_hit && id_branch_i;
      br_mem_load = mem_hit && mem_load_i && id_branch_i;
      stall       = load_use || br_ex || br_mem_load;
   end

   assign pc_we_o       = !stall;
   assign ifid_we_o     = !stall;
   assign idex_bubble_o = stall;
   assign ifid_flush_o  = taken && !stall;

   // R1: a load in execute feeding a used source must hold the front
   p_load_use_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_load_i && ex_wr_i && ex_rd_i != '0 && id_use_rs_i && id_rs_i == ex_rd_i)
      |-> (!pc_we_o && !ifid_we_o && idex_bubble_o));

   // R6: a branch waits on a load still in memory
   p_branch_load_mem_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (id_branch_i && mem_load_i && mem_wr_i && mem_rd_i != '0 &&
       id_use_rt_i && id_rt_i == mem_rd_i) |-> idex_bubble_o);

   // R7: register 0 alone never holds the pipeline
   p_zero_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_HARD && ex_rd_i == '0 && mem_rd_i == '0) |-> pc_we_o);

   // R9: a flush only comes from an unstalled branch
   p_flush_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_flush_o |-> (id_branch_i && pc_we_o && ifid_we_o));

   // R10: no branch and no load in execute means no hold
   p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_branch_i && !ex_load_i) |-> (pc_we_o && !ifid_flush_o));
endmodule

// File: tb/test_hazard_ctrl.sv
module test_hazard_ctrl;
   localparam int AW = 5;
   localparam int DW = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] id_rs, id_rt, ex_rd, mem_rd;
   logic id_use_rs, id_use_rt, id_branch, id_kind;
   logic [DW-1:0] opa, opb;
   logic ex_wr, ex_load, mem_wr, mem_load;
   logic pc_we, ifid_we, bubble, flush;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   hazard_ctrl i_hazard_ctrl (
      .clk(clk), .rst_n(rst_n),
      .id_rs_i(id_rs), .id_rt_i(id_rt), .id_use_rs_i(id_use_rs), .id_use_rt_i(id_use_rt),
      .id_branch_i(id_branch), .id_br_kind_i(id_kind), .id_opa_i(opa), .id_opb_i(opb),
      .ex_rd_i(ex_rd), .ex_wr_i(ex_wr), .ex_load_i(ex_load),
      .mem_rd_i(mem_rd), .mem_wr_i(mem_wr), .mem_load_i(mem_load),
      .pc_we_o(pc_we), .ifid_we_o(ifid_we), .idex_bubble_o(bubble), .ifid_flush_o(flush)
   );

   task automatic set_id(input int rs, input int rt, input bit ur, input bit ut,
                         input bit br, input bit kind, input int a, input int b);
      id_rs = AW'(rs); id_rt = AW'(rt); id_use_rs = ur; id_use_rt = ut;
      id_branch = br; id_kind = kind; opa = DW'(a); opb = DW'(b);
   endtask

   task automatic set_ex(input int rd, input bit wr, input bit ld);
      ex_rd = AW'(rd); ex_wr = wr; ex_load = ld;
   endtask

   task automatic set_mem(input int rd, input bit wr, input bit ld);
      mem_rd = AW'(rd); mem_wr = wr; mem_load = ld;
   endtask

   // apply after a falling edge, sample 1 ns later, away from the rising edge
   task automatic step_check(input bit exp_stall, input bit exp_flush, input string req);
      #1;
      checks++;
      if (pc_we !== !exp_stall || ifid_we !== !exp_stall || bubble !== exp_stall ||
          flush !== exp_flush) begin
         fails++;
         $display("FAIL %s: pc_we=%b ifid_we=%b bubble=%b flush=%b expected %b %b %b %b",
                  req, pc_we, ifid_we, bubble, flush, !exp_stall, !exp_stall, exp_stall, exp_flush);
      end
      @(negedge clk);
   endtask

   task automatic idle_all();
      set_id(0, 0, 0, 0, 0, 0, 0, 0);
      set_ex(0, 0, 0);
      set_mem(0, 0, 0);
   endtask

   task automatic t_reset_state();
      idle_all();
      step_check(1'b0, 1'b0, "R10 reset idle");
   endtask

   task automatic t_load_use();
      set_ex(8, 1, 1); set_mem(0, 0, 0);
      set_id(8, 3, 1, 1, 0, 0, 0, 0);
      step_check(1'b1, 1'b0, "R1 R2 R3 load-use rs");
      set_ex(0, 0, 0); set_mem(8, 1, 1);
      step_check(1'b0, 1'b0, "R1 one cycle only");
      set_ex(12, 1, 1); set_mem(0, 0, 0);
      set_id(4, 12, 1, 1, 0, 0, 0, 0);
      step_check(1'b1, 1'b0, "R1 load-use rt");
   endtask

   task automatic t_alu_branch();
      set_ex(9, 1, 0); set_mem(0, 0, 0);
      set_id(9, 3, 1, 1, 1, 0, 77, 77);
      step_check(1'b1, 1'b0, "R5 R9 alu then beq stalls, no flush");
      set_ex(0, 0, 0); set_mem(9, 1, 0);
      step_check(1'b0, 1'b1, "R5 R4 alu in mem, beq taken");
   endtask

   task automatic t_load_branch();
      set_ex(10, 1, 1); set_mem(0, 0, 0);
      set_id(2, 10, 1, 1, 1, 1, 5, 6);
      step_check(1'b1, 1'b0, "R6 load in ex, bne stalls");
      set_ex(0, 0, 0); set_mem(10, 1, 1);
      step_check(1'b1, 1'b0, "R6 R9 load in mem, bne stalls");
      set_mem(0, 0, 0);
      step_check(1'b0, 1'b1, "R6 R4 bne resolves taken");
   endtask

   task automatic t_branch_kinds();
      idle_all();
      set_id(1, 2, 1, 1, 1, 0, 3, 4);
      step_check(1'b0, 1'b0, "R4 beq unequal not taken");
      set_id(1, 2, 1, 1, 1, 1, 4, 4);
      step_check(1'b0, 1'b0, "R4 bne equal not taken");
   endtask

   task automatic t_zero_reg();
      set_ex(0, 1, 1); set_mem(0, 1, 1);
      set_id(0, 0, 1, 1, 1, 0, 1, 2);
      step_check(1'b0, 1'b0, "R7 register 0 no hazard");
   endtask

   task automatic t_no_write();
      set_ex(6, 0, 1); set_mem(0, 0, 0);
      set_id(6, 6, 1, 1, 0, 0, 0, 0);
      step_check(1'b0, 1'b0, "R8 producer without write");
      set_ex(6, 1, 1);
      set_id(6, 6, 0, 0, 0, 0, 0, 0);
      step_check(1'b0, 1'b0, "R8 unused sources");
   endtask

   task automatic t_nonbranch();
      idle_all();
      set_id(7, 7, 1, 1, 0, 0, 9, 9);
      step_check(1'b0, 1'b0, "R10 non-branch never flushes");
      set_mem(7, 1, 1);
      step_check(1'b0, 1'b0, "R1 load in mem, non-branch free");
   endtask

   initial begin : watchdog
      #400000;
      fails++;
      checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      idle_all();
      @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      t_load_use();
      t_alu_branch();
      t_load_branch();
      t_branch_kinds();
      t_zero_reg();
      t_no_write();
      t_nonbranch();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule